// File: doc/BRIEF.md
# Preloadable Up-Counter with Event Counting and Single-Shot Pulse-Width Capture

The block is an up-counter with a reload value, a power-of-two clock divider and a small register port. Software picks one of four modes. In halted mode the count is frozen. In event mode the count steps on edges of an external pin. In timer mode it steps on divided system-clock ticks. In capture mode it measures the width of one pulse on the external pin. When the count steps past all ones, it reloads from the preload register and raises a one-cycle interrupt request, which an enable bit can mask.

Capture is single-shot. After the start edge, the counter advances on divided clock ticks until the pin returns to its idle level. The hardware then clears the run bit, so the residual count holds the pulse length. Later pin activity is ignored until software sets the run bit again. The external pin passes through a two-flop synchronizer, and all edges are taken from the synchronized signal.

The register port is a plain single-cycle write strobe with an address. Read data is combinational from the address. No stream traffic crosses the block edge, so no valid/ready handshake is involved.

Top module: `evt_timer`

## Requirements
- R1: After reset, the control register (address 0), the preload register (address 1), the count (address 2) and `irq_o` all read 0.
- R2: A write to the preload register always updates the preload value. It also loads the count, but only while the run bit (control bit 2) is 0. While the run bit is 1, the count is not affected.
- R3: In timer mode (control bits [1:0] = 2'b10), with prescale field N in control bits [6:4], the count after M clock cycles following the enabling write equals P + floor(M / 2^N), where P is the starting count and there is no overflow. The divider restarts whenever the run bit goes from 0 to 1.
- R4: A count step taken at all ones loads the preload value instead. `irq_o` is high for exactly the one cycle in which the reloaded value is first visible, provided control bit 7 (interrupt enable) is 1.
- R5: With control bit 7 at 0, `irq_o` stays low, and overflow still reloads the preload value.
- R6: In event mode (bits [1:0] = 2'b01), each synchronized pin edge of the selected polarity adds one to the count, whatever the prescale field is. Edge select (control bit 3) at 0 picks rising edges and at 1 picks falling edges. Edges of the other polarity do not change the count.
- R7: In capture mode (bits [1:0] = 2'b11) with edge select 0, a rising edge starts the measurement and the next falling edge ends it. With edge select 1, the roles are swapped. A pulse of W clock cycles leaves the count at P + floor(W / 2^N), with overflow reloading as in R4.
- R8: The end of a capture clears the run bit in hardware. The count is then held, and further pin edges leave it unchanged until software sets the run bit again.
- R9: In timer and event modes, the run bit is never cleared by hardware, including across an overflow.
- R10: In halted mode (bits [1:0] = 2'b00), the count does not change except through a preload write while the run bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 control, 1 preload, 2 count |
| reg_wdata_i | input | CNT_W | Write data |
| reg_rdata_o | output | CNT_W | Read data for the addressed register |
| tpin_i | input | 1 | External timer pin, asynchronous |
| irq_o | output | 1 | One-cycle overflow interrupt request |

## Verification
The assertions check the following on every cycle:
- The count only steps by one or jumps to the preload value, outside writes.
- An interrupt always coincides with the reloaded value and with the interrupt enable from the previous cycle.
- Only capture mode ever clears the run bit without a write, and that bit stays low until written.
- A halted counter does not move.

The following can only be shown by the bench scenarios:
- The arithmetic relation between elapsed cycles, prescale field and final count.
- The measured width of pulses in both polarities.
- That edges of the wrong polarity, or edges arriving after a finished capture, leave the count untouched.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  typedef enum logic [1:0] {
    MODE_HALT    = 2'b00,
    MODE_EVENT   = 2'b01,
    MODE_TIMER   = 2'b10,
    MODE_CAPTURE = 2'b11
  } tmode_e;

  localparam int PSC_FIELD_W = 3;

  // control word, MSB first: irq enable, prescale, edge select, run, mode
  typedef struct packed {
    logic                   irq_en;
    logic [PSC_FIELD_W-1:0] psc;
    logic                   edge_sel;
    logic                   run;
    tmode_e                 mode;
  } ctrl_t;

  localparam int CTRL_W    = $bits(ctrl_t);
  localparam int BIT_RUN   = 2;
  localparam int BIT_IRQEN = CTRL_W - 1;

  localparam logic [1:0] ADDR_CTRL    = 2'd0;
  localparam logic [1:0] ADDR_PRELOAD = 2'd1;
  localparam logic [1:0] ADDR_COUNT   = 2'd2;

endpackage

// File: rtl/evt_timer_sync.sv
module evt_timer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;
  logic              synced;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      last_q  <= synced;
    end
  end

  assign synced = chain_q[STAGES-1];
  assign rise_o = synced & ~last_q;
  assign fall_o = ~synced & last_q;
endmodule

// File: rtl/evt_timer_psc.sv
module evt_timer_psc #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit;

  assign limit  = DIV_W'((32'd1 << sel_i) - 32'd1);
  assign tick_o = run_i && (div_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       div_q <= '0;
    else if (!run_i)   div_q <= '0;
    else if (tick_o)   div_q <= '0;
    else               div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/evt_timer_cap.sv
module evt_timer_cap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  input  logic start_i,
  input  logic stop_i,
  output logic measuring_o,
  output logic done_o
);
  typedef enum logic {CAP_WAIT, CAP_MEASURE} cap_st_e;
  cap_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!armed_i) st_d = CAP_WAIT;
    else if (st_q == CAP_WAIT && start_i) st_d = CAP_MEASURE;
    else if (st_q == CAP_MEASURE && stop_i) st_d = CAP_WAIT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= CAP_WAIT;
    else         st_q <= st_d;
  end

  assign measuring_o = armed_i && (st_q == CAP_MEASURE);
  assign done_o      = measuring_o && stop_i;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [CNT_W-1:0] reg_wdata_i,
  output logic [CNT_W-1:0] reg_rdata_o,
  input  logic             tpin_i,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = {CNT_W{1'b1}};

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] preload_q;
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;

  logic pin_rise, pin_fall;
  logic sel_edge, start_edge, stop_edge;
  logic psc_run, psc_tick;
  logic cap_armed, cap_meas, cap_done;
  logic step, wrap;
  logic wr_ctrl, wr_pre;

  evt_timer_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (tpin_i),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  assign start_edge = ctrl_q.edge_sel ? pin_fall : pin_rise;
  assign stop_edge  = ctrl_q.edge_sel ? pin_rise : pin_fall;
  assign sel_edge   = start_edge;

  assign cap_armed = ctrl_q.run && (ctrl_q.mode == MODE_CAPTURE);

  evt_timer_cap u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .armed_i     (cap_armed),
    .start_i     (start_edge),
    .stop_i      (stop_edge),
    .measuring_o (cap_meas),
    .done_o      (cap_done)
  );

  assign psc_run = ctrl_q.run &&
                   ((ctrl_q.mode == MODE_TIMER) || cap_meas);

  evt_timer_psc #(.SEL_W(PSC_FIELD_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (psc_run),
    .sel_i  (ctrl_q.psc),
    .tick_o (psc_tick)
  );

  always_comb begin
    unique case (ctrl_q.mode)
      MODE_EVENT:   step = ctrl_q.run && sel_edge;
      MODE_TIMER:   step = psc_tick;
      MODE_CAPTURE: step = psc_tick;
      default:      step = 1'b0;
    endcase
  end

  assign wrap    = step && (cnt_q == CNT_FULL);
  assign wr_ctrl = reg_we_i && (reg_addr_i == ADDR_CTRL);
  assign wr_pre  = reg_we_i && (reg_addr_i == ADDR_PRELOAD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
    end else if (cap_done) begin
      ctrl_q.run <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     preload_q <= '0;
    else if (wr_pre) preload_q <= reg_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (wr_pre && !ctrl_q.run) cnt_q <= reg_wdata_i;
    else if (wrap)                 cnt_q <= preload_q;
    else if (step)                 cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= wrap && ctrl_q.irq_en;
  end

  assign irq_o = irq_q;

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CTRL:    reg_rdata_o = CNT_W'(ctrl_q);
      ADDR_PRELOAD: reg_rdata_o = preload_q;
      ADDR_COUNT:   reg_rdata_o = cnt_q;
      default:      reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we,
  input logic [1:0]        addr,
  input logic [CTRL_W-1:0] ctrl,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  pre,
  input logic              irq_o
);
  logic wctl;
  assign wctl = we && (addr == ADDR_CTRL);

  // R4
  irq_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cnt == pre));

  // R5
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(ctrl[BIT_IRQEN]));

  // R9
  hw_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ctrl[BIT_RUN]) && !$past(wctl)) |-> ($past(ctrl[1:0]) == 2'b11));

  // R8
  stay_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(ctrl[BIT_RUN]) && !$past(wctl)) |-> !ctrl[BIT_RUN]);

  // R10
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(ctrl[1:0]) == 2'b00) && !$past(we)) |-> $stable(cnt));

  // R3
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(we) && (cnt != $past(cnt))) |-> ((cnt == $past(cnt) + 1'b1) || (cnt == pre)));
endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we     (reg_we_i),
  .addr   (reg_addr_i),
  .ctrl   (ctrl_q),
  .cnt    (cnt_q),
  .pre    (preload_q),
  .irq_o  (irq_o)
);

// File: tb/tb_evt_timer.sv
module tb_evt_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       pin = 1'b0;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  evt_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tpin_i(pin), .irq_o(irq)
  );

  function automatic logic [7:0] mk(bit ie, int n, bit es, bit run, int mode);
    return {ie, 3'(n), es, run, 2'(mode)};
  endfunction

  function automatic int expect_cnt(int p, int ev);
    int per = 256 - p;
    if (ev < per) return p + ev;
    return p + (ev - per) % per;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output int d);
    addr = a;
    #1;
    d = int'(rdata);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int v;
    int pv[3] = '{0, 100, 250};
    int mv[6] = '{0, 1, 3, 13, 40, 300};
    int wv[6] = '{1, 2, 3, 7, 16, 33};
    int base;

    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", v, 0);
    rd(2'd1, v); check("R1 preload", v, 0);
    rd(2'd2, v); check("R1 count", v, 0);
    check("R1 irq", int'(irq), 0);

    // R2 preload write loads count only while stopped
    wr(2'd1, 8'h37);
    rd(2'd2, v); check("R2 load while stopped", v, 8'h37);
    wr(2'd0, mk(0, 7, 0, 1, 2));
    wr(2'd1, 8'h80);
    rd(2'd2, v); check("R2 count kept while running", v, 8'h37);
    rd(2'd1, v); check("R2 preload updated", v, 8'h80);

    // R10 halted mode holds the count
    wr(2'd0, mk(0, 0, 0, 0, 0));
    wr(2'd1, 8'd9);
    wr(2'd0, mk(0, 0, 0, 1, 0));
    idle(50);
    rd(2'd2, v); check("R10 halt holds", v, 9);

    // R3 timer sweep over prescale, preload and elapsed cycles
    for (int n = 0; n < 8; n++)
      for (int pi = 0; pi < 3; pi++)
        for (int mi = 0; mi < 6; mi++) begin
          wr(2'd0, mk(0, n, 0, 0, 2));
          wr(2'd1, 8'(pv[pi]));
          wr(2'd0, mk(0, n, 0, 1, 2));
          idle(mv[mi]);
          rd(2'd2, v);
          check("R3 timer count", v, expect_cnt(pv[pi], mv[mi] >> n));
        end

    // R4 / R9 overflow with interrupt enabled
    wr(2'd0, mk(1, 0, 0, 0, 2));
    wr(2'd1, 8'd250);
    wr(2'd0, mk(1, 0, 0, 1, 2));
    idle(5);
    rd(2'd2, v); check("R4 count before wrap", v, 255);
    check("R4 irq low before wrap", int'(irq), 0);
    idle(1);
    rd(2'd2, v); check("R4 reload value", v, 250);
    check("R4 irq pulse", int'(irq), 1);
    idle(1);
    check("R4 irq one cycle", int'(irq), 0);
    rd(2'd0, v); check("R9 run kept after overflow", (v >> 2) & 1, 1);

    // R5 masked interrupt
    wr(2'd0, mk(0, 0, 0, 0, 2));
    wr(2'd1, 8'd250);
    wr(2'd0, mk(0, 0, 0, 1, 2));
    idle(6);
    rd(2'd2, v); check("R5 reload without irq", v, 250);
    check("R5 irq masked", int'(irq), 0);

    // R6 event mode, both polarities, prescale ignored
    for (int es = 0; es < 2; es++) begin
      pin = 1'b0;
      wr(2'd0, mk(0, 5, es[0], 0, 1));
      idle(4);
      wr(2'd1, 8'd20);
      wr(2'd0, mk(0, 5, es[0], 1, 1));
      base = 20;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk); pin = 1'b1; idle(4);
        if (es == 0) base++;
        rd(2'd2, v); check("R6 after rising edge", v, base);
        @(negedge clk); pin = 1'b0; idle(4);
        if (es == 1) base++;
        rd(2'd2, v); check("R6 after falling edge", v, base);
      end
      rd(2'd0, v); check("R9 run kept in event mode", (v >> 2) & 1, 1);
    end

    // R7 / R8 capture sweep
    for (int es = 0; es < 2; es++)
      for (int n = 0; n < 4; n++)
        for (int wi = 0; wi < 6; wi++) begin
          pin = es[0];
          wr(2'd0, mk(0, n, es[0], 0, 3));
          idle(4);
          wr(2'd1, 8'd10);
          wr(2'd0, mk(0, n, es[0], 1, 3));
          idle(5);
          rd(2'd2, v); check("R7 armed no count", v, 10);
          pin = ~es[0];
          idle(wv[wi]);
          pin = es[0];
          idle(6);
          rd(2'd2, v); check("R7 pulse width", v, 10 + (wv[wi] >> n));
          rd(2'd0, v); check("R8 run cleared", (v >> 2) & 1, 0);
          pin = ~es[0]; idle(10);
          pin = es[0]; idle(4);
          rd(2'd2, v); check("R8 later edges ignored", v, 10 + (wv[wi] >> n));
        end

    // R7 capture spanning overflow
    pin = 1'b0;
    wr(2'd0, mk(0, 0, 0, 0, 3));
    idle(4);
    wr(2'd1, 8'd254);
    wr(2'd0, mk(0, 0, 0, 1, 3));
    idle(3);
    pin = 1'b1; idle(5); pin = 1'b0; idle(6);
    rd(2'd2, v); check("R7 capture with reload", v, expect_cnt(254, 5));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule